// File: doc/BRIEF.md
# Serial Game-Pad Port Register Block

This block connects a simple 8-bit CPU bus to two serial game-pad ports. A write to the strobe address captures three bits and holds them as output levels. Bit 0 drives the pad-port OUT line and bits 2:1 drive the two expansion OUT lines. A pad loads its buttons while OUT is high and shifts them out serially once OUT drops back to low.

A read from one of the two port addresses pulls that port's clock line low for that bus cycle only. While the clock is low, the block captures the port's five data inputs. The captured levels come back inverted in the low five bits of the read byte. The upper three bits, and any line configured as open bus, repeat the last byte seen on the data bus. For each port, every data line can be configured by parameter as connected, forced to zero, or open bus.

A bus cycle is one cycle of the system clock with a valid address and a read or write strobe. The read byte is registered and appears on `bus_rdata` in the cycle after the read. `bus_rdata` always shows the last byte on the bus, which is also the open-bus value. A cycle with both strobes asserted is not a legal bus cycle.

Top module: `pad_port_regs`

## Requirements
- R1: While reset is held, `pad_out` is 000, `bus_rdata` is 0x00, and both port clock lines are high.
- R2: A write to the strobe address (default 0x4016) loads `bus_wdata[2:0]` into `pad_out`, visible from the next cycle. `pad_out[0]` is the pad-port OUT line and `pad_out[2:1]` are the expansion OUT lines. Written bits 7:3 have no effect on `pad_out`.
- R3: `pad_out` keeps its value through reads, through idle cycles, and through writes to any address other than the strobe address.
- R4: `pad_a_clk_n` is low exactly during a cycle that reads the port A address (default 0x4016), and `pad_b_clk_n` is low exactly during a cycle that reads the port B address (default 0x4017). In every other cycle, including writes to those addresses, both are high.
- R5: For a line in connected mode (mode code 2'b00), the read byte bit i equals the inverse of data pin i as sampled during the low clock phase. Pin i maps to read bit i, for i = 0..4.
- R6: Bits 7:5 of a port read equal bits 7:5 of the bus byte that preceded the read.
- R7: For a line in forced-zero mode (mode code 2'b01), the read bit is 0 whatever the pin level. The mode of line i sits at parameter bits [2i+1:2i].
- R8: For a line in open-bus mode (mode code 2'b10), the read bit equals the same bit of the preceding bus byte, whatever the pin level. Default modes: port A lines 0,2 connected, line 1 forced zero, lines 3,4 open bus. Port B lines 0,3,4 connected, lines 1,2 forced zero.
- R9: Any bus write makes its byte the bus value shown on `bus_rdata` from the next cycle. Reads of addresses other than the two port addresses, and idle cycles, leave `bus_rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; one cycle is one bus cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Bus address |
| bus_rd | input | 1 | Read strobe for this cycle |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Last bus byte, including the result of the last port read |
| pad_out | output | 3 | Held strobe bits: [0] pad OUT, [2:1] expansion OUT |
| pad_a_clk_n | output | 1 | Port A clock, low during a port A read |
| pad_b_clk_n | output | 1 | Port B clock, low during a port B read |
| pad_a_dat | input | 5 | Port A data lines 4..0 |
| pad_b_dat | input | 5 | Port B data lines 4..0 |

## Verification
Random pin levels on port reads show whether connected lines are inverted, while forced-zero and open-bus lines stay independent of the pins. Reads with all pins low and all pins high, preceded by writes of 0x1F and 0x00, tell a forced-zero line apart from an open-bus line. They also tell a bit taken from the previous bus byte apart from one taken from the pin. Writes whose upper bits are set check that only three bits reach the OUT lines. Writes and reads to neighbouring addresses check the address decode for the clocks, the OUT latch and the held bus byte.

// File: rtl/pad_port_pkg.sv
package pad_port_pkg;

   typedef enum logic [1:0] {
      LINE_LIVE  = 2'b00,
      LINE_ZERO  = 2'b01,
      LINE_FLOAT = 2'b10
   } line_mode_e;

   localparam int unsigned NPORTS = 2;

   function automatic logic mode_ok(logic [1:0] m);
      return (m == LINE_LIVE) || (m == LINE_ZERO) || (m == LINE_FLOAT);
   endfunction

   function automatic logic line_pick(logic [1:0] m, logic pin, logic prev);
      logic r;
      case (m)
         LINE_LIVE: r = ~pin;
         LINE_ZERO: r = 1'b0;
         default:   r = prev;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/pad_port_decode.sv
module pad_port_decode
   import pad_port_pkg::*;
#(
   parameter int unsigned              ADDR_W      = 16,
   parameter logic [ADDR_W-1:0]        STROBE_ADDR = 16'h4016,
   parameter logic [NPORTS*ADDR_W-1:0] PORT_ADDRS  = {16'h4017, 16'h4016}
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              rd_i,
   input  logic              wr_i,
   output logic              strobe_we_o,
   output logic [NPORTS-1:0] rd_hit_o,
   output logic [NPORTS-1:0] port_clk_n_o
);

   assign strobe_we_o = wr_i && (addr_i == STROBE_ADDR);

   for (genvar k = 0; k < NPORTS; k++) begin : g_port
      localparam logic [ADDR_W-1:0] PA = PORT_ADDRS[k*ADDR_W +: ADDR_W];
      logic match;
      assign match           = (addr_i == PA);
      assign rd_hit_o[k]     = rd_i && match;
      assign port_clk_n_o[k] = ~(rd_i && match);
   end

endmodule

// File: rtl/pad_port_latch.sv
module pad_port_latch #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned OUT_BITS = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we_i,
   input  logic [DATA_W-1:0]   wdata_i,
   output logic [OUT_BITS-1:0] q_o
);

   if (OUT_BITS > DATA_W) begin : g_bad_width
      $error("pad_port_latch: OUT_BITS exceeds DATA_W");
   end

   logic [OUT_BITS-1:0] q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (we_i) q <= wdata_i[OUT_BITS-1:0];
   end

   assign q_o = q;

endmodule

// File: rtl/pad_port_linesel.sv
module pad_port_linesel
   import pad_port_pkg::*;
#(
   parameter int unsigned             LINES = 5,
   parameter logic [2*LINES-1:0]      MODES = '0
) (
   input  logic [LINES-1:0] pin_i,
   input  logic [LINES-1:0] prev_i,
   output logic [LINES-1:0] sel_o
);

   for (genvar i = 0; i < LINES; i++) begin : g_chk
      if (!mode_ok(MODES[2*i +: 2])) begin : g_bad_mode
         $error("pad_port_linesel: illegal mode code on a data line");
      end
   end

   always_comb begin
      for (int i = 0; i < LINES; i++) begin
         sel_o[i] = line_pick(MODES[2*i +: 2], pin_i[i], prev_i[i]);
      end
   end

endmodule

// File: rtl/pad_port_regs.sv
module pad_port_regs
   import pad_port_pkg::*;
#(
   parameter int unsigned         ADDR_W      = 16,
   parameter int unsigned         DATA_W      = 8,
   parameter int unsigned         OUT_BITS    = 3,
   parameter int unsigned         LINES       = 5,
   parameter logic [ADDR_W-1:0]   STROBE_ADDR = 16'h4016,
   parameter logic [ADDR_W-1:0]   PORT_A_ADDR = 16'h4016,
   parameter logic [ADDR_W-1:0]   PORT_B_ADDR = 16'h4017,
   parameter logic [2*LINES-1:0]  MODES_A     = 10'b10_10_00_01_00,
   parameter logic [2*LINES-1:0]  MODES_B     = 10'b00_00_01_01_00
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_rd,
   input  logic                bus_wr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   output logic [OUT_BITS-1:0] pad_out,
   output logic                pad_a_clk_n,
   output logic                pad_b_clk_n,
   input  logic [LINES-1:0]    pad_a_dat,
   input  logic [LINES-1:0]    pad_b_dat
);

   localparam logic [NPORTS*ADDR_W-1:0] PORT_ADDRS = {PORT_B_ADDR, PORT_A_ADDR};
   localparam logic [NPORTS*2*LINES-1:0] ALL_MODES = {MODES_B, MODES_A};

   if (LINES >= DATA_W) begin : g_bad_lines
      $error("pad_port_regs: LINES must leave an open-bus field");
   end
   if (PORT_A_ADDR == PORT_B_ADDR) begin : g_bad_addr
      $error("pad_port_regs: port addresses must differ");
   end

   logic              strobe_we;
   logic [NPORTS-1:0] rd_hit;
   logic [NPORTS-1:0] clk_n;
   logic [LINES-1:0]  pins [NPORTS];
   logic [LINES-1:0]  sel  [NPORTS];
   logic [DATA_W-1:0] bus_q, bus_d;

   pad_port_decode #(
      .ADDR_W      (ADDR_W),
      .STROBE_ADDR (STROBE_ADDR),
      .PORT_ADDRS  (PORT_ADDRS)
   ) u_decode (
      .addr_i       (bus_addr),
      .rd_i         (bus_rd),
      .wr_i         (bus_wr),
      .strobe_we_o  (strobe_we),
      .rd_hit_o     (rd_hit),
      .port_clk_n_o (clk_n)
   );

   pad_port_latch #(
      .DATA_W   (DATA_W),
      .OUT_BITS (OUT_BITS)
   ) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (strobe_we),
      .wdata_i (bus_wdata),
      .q_o     (pad_out)
   );

   assign pins[0] = pad_a_dat;
   assign pins[1] = pad_b_dat;

   for (genvar k = 0; k < NPORTS; k++) begin : g_sel
      pad_port_linesel #(
         .LINES (LINES),
         .MODES (ALL_MODES[k*2*LINES +: 2*LINES])
      ) u_sel (
         .pin_i  (pins[k]),
         .prev_i (bus_q[LINES-1:0]),
         .sel_o  (sel[k])
      );
   end

   always_comb begin
      bus_d = bus_q;
      if (bus_wr) begin
         bus_d = bus_wdata;
      end else begin
         for (int k = 0; k < NPORTS; k++) begin
            if (rd_hit[k]) bus_d[LINES-1:0] = sel[k];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_q <= '0;
      else        bus_q <= bus_d;
   end

   assign bus_rdata   = bus_q;
   assign pad_a_clk_n = clk_n[0];
   assign pad_b_clk_n = clk_n[1];

endmodule

// File: rtl/pad_port_chk.sv
module pad_port_chk #(
   parameter int unsigned       ADDR_W      = 16,
   parameter int unsigned       DATA_W      = 8,
   parameter int unsigned       OUT_BITS    = 3,
   parameter int unsigned       LINES       = 5,
   parameter logic [ADDR_W-1:0] STROBE_ADDR = 16'h4016,
   parameter logic [ADDR_W-1:0] PORT_A_ADDR = 16'h4016,
   parameter logic [ADDR_W-1:0] PORT_B_ADDR = 16'h4017
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic                bus_rd,
   input logic                bus_wr,
   input logic [DATA_W-1:0]   bus_wdata,
   input logic [DATA_W-1:0]   bus_rdata,
   input logic [OUT_BITS-1:0] pad_out,
   input logic                pad_a_clk_n,
   input logic                pad_b_clk_n
);

   logic port_read;
   assign port_read = bus_rd && !bus_wr &&
                      (bus_addr == PORT_A_ADDR || bus_addr == PORT_B_ADDR);

   // R4
   clk_a_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pad_a_clk_n |-> (bus_rd && bus_addr == PORT_A_ADDR));

   // R4
   clk_b_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pad_b_clk_n |-> (bus_rd && bus_addr == PORT_B_ADDR));

   // R4
   clk_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({~pad_a_clk_n, ~pad_b_clk_n}));

   // R2
   strobe_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == STROBE_ADDR) |=> (pad_out == $past(bus_wdata[OUT_BITS-1:0])));

   // R3
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == STROBE_ADDR) |=> $stable(pad_out));

   // R6
   upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      port_read |=> (bus_rdata[DATA_W-1:LINES] == $past(bus_rdata[DATA_W-1:LINES])));

   // R9
   write_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr |=> (bus_rdata == $past(bus_wdata)));

   // R9
   bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_wr && !port_read) |=> $stable(bus_rdata));

endmodule

bind pad_port_regs pad_port_chk #(
   .ADDR_W      (ADDR_W),
   .DATA_W      (DATA_W),
   .OUT_BITS    (OUT_BITS),
   .LINES       (LINES),
   .STROBE_ADDR (STROBE_ADDR),
   .PORT_A_ADDR (PORT_A_ADDR),
   .PORT_B_ADDR (PORT_B_ADDR)
) u_pad_port_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_addr    (bus_addr),
   .bus_rd      (bus_rd),
   .bus_wr      (bus_wr),
   .bus_wdata   (bus_wdata),
   .bus_rdata   (bus_rdata),
   .pad_out     (pad_out),
   .pad_a_clk_n (pad_a_clk_n),
   .pad_b_clk_n (pad_b_clk_n)
);

// File: tb/test_pad_port_regs.sv
module test_pad_port_regs;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_addr = '0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [2:0]  pad_out;
   logic        pad_a_clk_n, pad_b_clk_n;
   logic [4:0]  pad_a_dat = '0;
   logic [4:0]  pad_b_dat = '0;

   always #5 clk = ~clk;

   pad_port_regs i_pad_port_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_addr    (bus_addr),
      .bus_rd      (bus_rd),
      .bus_wr      (bus_wr),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .pad_out     (pad_out),
      .pad_a_clk_n (pad_a_clk_n),
      .pad_b_clk_n (pad_b_clk_n),
      .pad_a_dat   (pad_a_dat),
      .pad_b_dat   (pad_b_dat)
   );

   // line modes from R7/R8: 0 connected, 1 forced zero, 2 open bus; index = line
   int mode_a [5] = '{0, 1, 0, 2, 2};
   int mode_b [5] = '{0, 1, 1, 0, 0};

   int   n_tests = 0;
   int   n_fail  = 0;
   bit   done    = 1'b0;
   logic [7:0] exp_bus = 8'h00;
   logic [2:0] exp_out = 3'b000;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic exp_bit(int m, logic pin, logic prev);
      if (m == 0) return ~pin;
      if (m == 1) return 1'b0;
      return prev;
   endfunction

   function automatic string mode_req(int m);
      if (m == 0) return "R5";
      if (m == 1) return "R7";
      return "R8";
   endfunction

   // called at a falling edge; returns at the next falling edge
   task automatic do_op(input logic rd, input logic wr, input logic [15:0] a,
                        input logic [7:0] wd, input logic [4:0] pa, input logic [4:0] pb);
      logic [7:0] prev;
      bit         is_a, is_b;
      bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
      pad_a_dat = pa; pad_b_dat = pb;
      is_a = rd && !wr && (a == 16'h4016);
      is_b = rd && !wr && (a == 16'h4017);
      #1;
      chk(pad_a_clk_n == !is_a, "R4", "port A clock", pad_a_clk_n, !is_a);
      chk(pad_b_clk_n == !is_b, "R4", "port B clock", pad_b_clk_n, !is_b);
      @(negedge clk);
      prev = exp_bus;
      if (wr && a == 16'h4016) begin
         exp_out = wd[2:0];
         chk(pad_out == exp_out, "R2", "strobe latch", pad_out, exp_out);
      end else begin
         chk(pad_out == exp_out, "R3", "OUT hold", pad_out, exp_out);
      end
      if (wr) begin
         exp_bus = wd;
         chk(bus_rdata == exp_bus, "R9", "bus after write", bus_rdata, exp_bus);
      end else if (is_a || is_b) begin
         for (int i = 0; i < 5; i++) begin
            int m;
            m = is_a ? mode_a[i] : mode_b[i];
            exp_bus[i] = exp_bit(m, is_a ? pa[i] : pb[i], prev[i]);
            chk(bus_rdata[i] == exp_bus[i], mode_req(m), $sformatf("read line %0d", i),
                bus_rdata[i], exp_bus[i]);
         end
         chk(bus_rdata[7:5] == prev[7:5], "R6", "open-bus upper bits",
             bus_rdata[7:5], prev[7:5]);
      end else begin
         chk(bus_rdata == exp_bus, "R9", "bus held", bus_rdata, exp_bus);
      end
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7113));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(pad_out == 3'b000, "R1", "reset OUT", pad_out, 0);
      chk(bus_rdata == 8'h00, "R1", "reset bus", bus_rdata, 0);
      chk(pad_a_clk_n && pad_b_clk_n, "R1", "reset clocks", {pad_a_clk_n, pad_b_clk_n}, 3);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: all bits set, only three reach OUT; then upper-only bits clear OUT
      do_op(0, 1, 16'h4016, 8'hFF, 5'h00, 5'h00);
      do_op(0, 1, 16'h4016, 8'hF8, 5'h00, 5'h00);
      do_op(0, 1, 16'h4016, 8'h05, 5'h00, 5'h00);
      // R3/R4/R9: write to port B address, read of a neighbour address
      do_op(0, 1, 16'h4017, 8'h1F, 5'h00, 5'h00);
      do_op(1, 0, 16'h4015, 8'h00, 5'h00, 5'h00);
      // R8 vs R7: pins all high after 0x1F, then pins low after 0x00
      do_op(1, 0, 16'h4016, 8'h00, 5'h1F, 5'h1F);
      do_op(0, 1, 16'h4000, 8'hE0, 5'h00, 5'h00);
      do_op(1, 0, 16'h4016, 8'h00, 5'h00, 5'h00);
      do_op(1, 0, 16'h4017, 8'h00, 5'h00, 5'h1F);
      do_op(0, 0, 16'h4017, 8'h00, 5'h1F, 5'h1F);

      for (int n = 0; n < 600; n++) begin
         int sel;
         logic [15:0] a;
         sel = int'($urandom_range(0, 9));
         case (sel)
            0, 1:    a = 16'h4016;
            2, 3:    a = 16'h4017;
            4:       a = 16'h4015;
            5:       a = 16'h4018;
            default: a = ($urandom_range(0, 1) == 0) ? 16'h4016 : 16'h4017;
         endcase
         if (sel == 6 || sel == 7)
            do_op(0, 1, a, 8'($urandom()), 5'($urandom()), 5'($urandom()));
         else if (sel == 9)
            do_op(0, 0, a, 8'($urandom()), 5'($urandom()), 5'($urandom()));
         else
            do_op(1, 0, a, 8'($urandom()), 5'($urandom()), 5'($urandom()));
      end
      do_op(0, 0, 16'h0000, 8'h00, 5'h00, 5'h00);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule